// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block holds the most recent page-number-to-frame-number translations so that repeated memory accesses can skip a page-table walk. A lookup presents a 20-bit virtual page number, a 12-bit page offset and the kind of access being made. One clock later the block reports one of three outcomes:

- a hit, with the physical address;
- a miss, when no valid entry matches;
- a protection fault, when an entry matches but its stored permissions forbid the access.

The incoming page number is compared against every entry at once.

After a walk, the fill port installs a translation. A fill goes to one of three places, in this order of preference:

- the entry that already holds the same page number;
- otherwise the lowest-numbered empty entry;
- otherwise the entry named by a round-robin pointer.

Two inputs empty the whole buffer: an explicit invalidate, and a strobe that marks a write of the page-directory base register. Coherence with other buffers, address-space tags and the walk itself are left to the surrounding logic.

Top module: `page_xlat_buf`

## Requirements
- R1: After reset every entry is invalid and all response outputs are 0. The first lookup of any page therefore reports a miss.
- R2: A lookup requested in cycle N is answered in cycle N+1 with `rsp_valid`=1 and exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. A cycle with no request gives all response outputs 0 in the next cycle.
- R3: On a hit, `rsp_pa` equals the stored frame number in bits 31:12, with the request's unchanged offset in bits 11:0.
- R4: When no valid entry holds the requested page number, the response is a miss with `rsp_pa`=0.
- R5: A fill makes the translation visible to lookups from the next cycle on. A lookup in the same cycle as the fill still sees the old contents.
- R6: A fill whose page number is already held by a valid entry overwrites that entry, so no page number is held twice.
- R7: Without a matching entry, a fill takes the lowest-indexed invalid entry. When all 16 entries are valid, it replaces the entry at a round-robin pointer instead. The pointer is 0 after reset and advances by one, modulo 16, only on such a replacement.
- R8: `inv_all` clears every entry at the end of its cycle. A fill in that same cycle is discarded.
- R9: `dirbase_wr` has exactly the same clearing effect as `inv_all`.
- R10: A lookup in the same cycle as `inv_all` or `dirbase_wr` reports a miss, even when an entry matches.
- R11: On a match the access is refused, and the response is a fault with `rsp_pa`=0, in either of two cases. The first is `lk_user`=1 (user-mode access) while the entry's user flag is 0 (supervisor only). The second is `lk_write`=1 while the entry's write flag is 0 (read only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset, passed through on a hit |
| lk_user | input | 1 | 1 = access made in user mode |
| lk_write | input | 1 | 1 = write access |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number of the new translation |
| fill_pfn | input | 20 | Frame number of the new translation |
| fill_user_ok | input | 1 | 1 = user mode may access the page |
| fill_wr_ok | input | 1 | 1 = page is writable |
| inv_all | input | 1 | Invalidate every entry |
| dirbase_wr | input | 1 | Directory base register written; invalidates every entry |
| rsp_valid | output | 1 | Response to last cycle's lookup |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No usable translation |
| rsp_fault | output | 1 | Translation found but access refused |
| rsp_pa | output | 32 | Physical address on a hit, 0 otherwise |

## Verification
Hits, misses and faults are each exercised with varied offsets. This separates a correct frame-plus-offset join from a dropped or shifted offset.

Fills are made in several situations: into an empty buffer, over a page number that is already held, and into a full buffer over several rounds. Together these separate lowest-free placement, in-place overwrite and the advance of the replacement pointer.

Lookups and fills are also placed in the same cycle as each of the two invalidation sources. This shows whether invalidation takes priority over a hit and whether it discards a concurrent fill.

A long pseudo-random run with a small pool of page numbers then mixes all of these cases against the bench's own model.

// File: rtl/pxb_pkg.sv
// Shared types for the page translation buffer.
// Assumes: permissions are one user flag and one write flag per entry.
package pxb_pkg;

    // Access rights kept per entry
    typedef struct packed {
        logic user_ok;   // 1 = user-mode access allowed
        logic wr_ok;     // 1 = writes allowed
    } perm_t;

    // Returns 1 when an access of the given kind is refused by the rights
    function automatic logic perm_denied(input perm_t p, input logic is_user, input logic is_write);
        return (is_user && !p.user_ok) || (is_write && !p.wr_ok);
    endfunction

endpackage

// File: rtl/pxb_cam.sv
// Entry storage and parallel tag compare for the translation buffer.
// Holds ENTRIES entries of {valid, tag, frame, rights}. It compares two
// page numbers (lookup and fill) against all entries every cycle, and
// reads out the fields of one selected entry.
// Assumes: clr has priority over a write in the same cycle.
module pxb_cam
    import pxb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  perm_t              wr_perm,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [VPN_W-1:0]   fl_vpn,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] fl_match,
    output logic [PFN_W-1:0]   rd_pfn,
    output perm_t              rd_perm
);

    logic [ENTRIES-1:0] v_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    perm_t              perm_q [ENTRIES];

    // Purpose: entry update, with whole-buffer clear taking precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                pfn_q[i]  <= '0;
                perm_q[i] <= '0;
            end
        end else if (clr) begin
            v_q <= '0;
        end else if (wr_en) begin
            v_q[wr_idx]    <= 1'b1;
            tag_q[wr_idx]  <= wr_vpn;
            pfn_q[wr_idx]  <= wr_pfn;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    // One comparator pair per entry
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign lk_match[e] = v_q[e] && (tag_q[e] == lk_vpn);
        assign fl_match[e] = v_q[e] && (tag_q[e] == fl_vpn);
    end

    assign valid_vec = v_q;

    // Purpose: read mux for the selected entry
    always_comb begin
        rd_pfn  = pfn_q[rd_idx];
        rd_perm = perm_q[rd_idx];
    end

endmodule

// File: rtl/pxb_victim.sv
// Fill placement for the translation buffer.
// Picks the entry a fill writes: a matching entry first, then the
// lowest-indexed invalid entry, then a round-robin pointer. The pointer
// moves only when it was used.
// Assumes: at most one entry matches the fill page number.
module pxb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] fl_match,
    input  logic               fill_go,
    output logic [IDX_W-1:0]   vic_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] hit_idx;
    logic             any_free;
    logic             any_hit;

    // Purpose: lowest free entry and matching entry encoders
    always_comb begin
        free_idx = '0;
        hit_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
            if (fl_match[i])   hit_idx  = IDX_W'(i);
        end
        any_free = ~&valid_vec;
        any_hit  = |fl_match;
    end

    // Purpose: select the destination by preference
    always_comb begin
        if (any_hit)       vic_idx = hit_idx;
        else if (any_free) vic_idx = free_idx;
        else               vic_idx = rr_q;
    end

    // Purpose: advance the replacement pointer when it supplied the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_go && !any_hit && !any_free) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/pxb_resp.sv
// Response stage of the translation buffer.
// Turns the match result, the selected entry and the access kind into a
// registered hit/miss/fault response with the physical address.
// Assumes: kill forces a miss whatever the match says.
module pxb_resp
    import pxb_pkg::*;
#(
    parameter int PFN_W  = 20,
    parameter int OFF_W  = 12,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             kill,
    input  logic             found,
    input  logic [PFN_W-1:0] pfn,
    input  perm_t            perm,
    input  logic             is_user,
    input  logic             is_write,
    input  logic [OFF_W-1:0] off,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa
);

    logic usable;
    logic denied;

    // Purpose: classify the outcome of this cycle's lookup
    always_comb begin
        usable = found && !kill;
        denied = perm_denied(perm, is_user, is_write);
    end

    // Purpose: register the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= req;
            rsp_hit   <= req && usable && !denied;
            rsp_miss  <= req && !usable;
            rsp_fault <= req && usable && denied;
            rsp_pa    <= (req && usable && !denied) ? {pfn, off} : '0;
        end
    end

endmodule

// File: rtl/page_xlat_buf.sv
// Fully associative page translation buffer (top level).
// Lookup answers one cycle later with hit, miss or fault. Fill installs a
// translation. inv_all or dirbase_wr clears every entry, discards a fill
// in the same cycle, and turns a lookup in that cycle into a miss.
// Assumes: the caller does not depend on coherence with other buffers.
module page_xlat_buf
    import pxb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PA_W   = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_off,
    input  logic             lk_user,
    input  logic             lk_write,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_user_ok,
    input  logic             fill_wr_ok,
    input  logic             inv_all,
    input  logic             dirbase_wr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa
);

    logic               kill;
    logic               fill_go;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [IDX_W-1:0]   vic_idx;
    logic [IDX_W-1:0]   lk_idx;
    logic [PFN_W-1:0]   rd_pfn;
    perm_t              rd_perm;
    perm_t              fill_perm;

    // Purpose: invalidation sources and fill qualification
    always_comb begin
        kill              = inv_all || dirbase_wr;
        fill_go           = fill_en && !kill;
        fill_perm.user_ok = fill_user_ok;
        fill_perm.wr_ok   = fill_wr_ok;
    end

    // Purpose: encode the matching lookup entry into an index
    always_comb begin
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) lk_idx = IDX_W'(i);
        end
    end

    pxb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (kill),
        .wr_en     (fill_go),
        .wr_idx    (vic_idx),
        .wr_vpn    (fill_vpn),
        .wr_pfn    (fill_pfn),
        .wr_perm   (fill_perm),
        .lk_vpn    (lk_vpn),
        .fl_vpn    (fill_vpn),
        .rd_idx    (lk_idx),
        .valid_vec (valid_vec),
        .lk_match  (lk_match),
        .fl_match  (fl_match),
        .rd_pfn    (rd_pfn),
        .rd_perm   (rd_perm)
    );

    pxb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .fl_match  (fl_match),
        .fill_go   (fill_go),
        .vic_idx   (vic_idx)
    );

    pxb_resp #(
        .PFN_W (PFN_W),
        .OFF_W (OFF_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lk_valid),
        .kill      (kill),
        .found     (|lk_match),
        .pfn       (rd_pfn),
        .perm      (rd_perm),
        .is_user   (lk_user),
        .is_write  (lk_write),
        .off       (lk_off),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_fault (rsp_fault),
        .rsp_pa    (rsp_pa)
    );

endmodule

// File: rtl/pxb_chk.sv
// Assertion checker for page_xlat_buf, attached with bind.
// Assumes: rst_n is held low for at least one clock at start.
module pxb_chk #(
    parameter int ENTRIES = 16,
    parameter int OFF_W   = 12,
    parameter int PA_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [OFF_W-1:0]   lk_off,
    input logic               inv_all,
    input logic               dirbase_wr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_pa,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] fl_match
);

    // R2: a request is answered next cycle with exactly one outcome
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_valid && $countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    // R2: no request, no response
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault));

    // R3: offset bits pass through unchanged on a hit
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_pa[OFF_W-1:0] == $past(lk_off)));

    // R4 / R11: no address leaks on a miss or fault
    a_r4_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault) |-> (rsp_pa == '0));

    // R6: the stored tags never hold a page number twice
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fl_match));

    // R8 / R9: a lookup right after an invalidation misses
    a_r8_empty_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(inv_all || dirbase_wr)) |=> rsp_miss);

    // R10: a lookup concurrent with an invalidation misses
    a_r10_kill_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (inv_all || dirbase_wr)) |=> rsp_miss);

endmodule

bind page_xlat_buf pxb_chk #(
    .ENTRIES (ENTRIES),
    .OFF_W   (OFF_W),
    .PA_W    (PA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_off     (lk_off),
    .inv_all    (inv_all),
    .dirbase_wr (dirbase_wr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_fault  (rsp_fault),
    .rsp_pa     (rsp_pa),
    .lk_match   (lk_match),
    .fl_match   (fl_match)
);

// File: tb/page_xlat_buf_tb.sv
module page_xlat_buf_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_user = 0, lk_write = 0;
    logic [19:0] lk_vpn = '0;
    logic [11:0] lk_off = '0;
    logic        fill_en = 0, fill_user_ok = 0, fill_wr_ok = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        inv_all = 0, dirbase_wr = 0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_pa;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    bit          m_v   [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];
    bit          m_u   [N];
    bit          m_w   [N];
    int          m_rr  = 0;

    always #4 clk = ~clk;

    page_xlat_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .lk_user(lk_user), .lk_write(lk_write),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_user_ok(fill_user_ok), .fill_wr_ok(fill_wr_ok),
        .inv_all(inv_all), .dirbase_wr(dirbase_wr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: inputs already set; predict, advance, update model, compare
    task automatic tick(input string tag);
        logic [35:0] exp;
        int hit_at;
        bit kill;
        exp = '0;
        kill = inv_all || dirbase_wr;
        hit_at = -1;
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == lk_vpn) hit_at = i;
        if (lk_valid) begin
            if (kill || hit_at < 0)
                exp = {4'b1010, 32'h0};
            else if ((lk_user && !m_u[hit_at]) || (lk_write && !m_w[hit_at]))
                exp = {4'b1001, 32'h0};
            else
                exp = {4'b1100, m_pfn[hit_at], lk_off};
        end
        @(posedge clk);
        if (kill) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (fill_en) begin
            int slot;
            slot = -1;
            for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == fill_vpn) slot = i;
            if (slot < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_pfn[slot] = fill_pfn;
            m_u[slot] = fill_user_ok; m_w[slot] = fill_wr_ok;
        end
        #1;
        check(tag, {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa}, exp);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        lk_valid = 0; fill_en = 0; inv_all = 0; dirbase_wr = 0;
        lk_user = 0; lk_write = 0;
    endtask

    task automatic look(input logic [19:0] v, input logic [11:0] o,
                        input bit usr, input bit wr, input string tag);
        idle_inputs();
        lk_valid = 1; lk_vpn = v; lk_off = o; lk_user = usr; lk_write = wr;
        tick(tag);
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p,
                        input bit u, input bit w, input string tag);
        idle_inputs();
        fill_en = 1; fill_vpn = v; fill_pfn = p; fill_user_ok = u; fill_wr_ok = w;
        tick(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_u[i] = 0; m_w[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa}, '0);
        rst_n = 1;
        @(negedge clk);
        look(20'h00042, 12'h123, 0, 0, "R1 first lookup miss");
        idle_inputs(); tick("R2 idle cycle");

        // R5: fill then hit; same-cycle lookup sees old contents
        idle_inputs();
        fill_en = 1; fill_vpn = 20'h00042; fill_pfn = 20'hABCDE; fill_user_ok = 1; fill_wr_ok = 1;
        lk_valid = 1; lk_vpn = 20'h00042; lk_off = 12'h555;
        tick("R5 lookup during fill");
        look(20'h00042, 12'h555, 1, 1, "R5 hit after fill");
        look(20'h00042, 12'hFFF, 0, 0, "R3 offset all ones");
        look(20'h00042, 12'h000, 1, 0, "R3 offset zero");
        fill(20'h12345, 20'h0F0F0, 0, 1, "R7 second fill");
        fill(20'hFFFFF, 20'h00001, 1, 0, "R7 third fill");
        look(20'h12345, 12'h7A1, 0, 1, "R3 hit supervisor page");
        look(20'h12346, 12'h7A1, 0, 0, "R4 neighbour miss");
        // R11: permission faults
        look(20'h12345, 12'h010, 1, 0, "R11 user on supervisor page");
        look(20'hFFFFF, 12'h010, 0, 1, "R11 write on read-only page");
        look(20'hFFFFF, 12'h010, 1, 0, "R11 user read allowed");
        // R6: refill same page overwrites in place
        fill(20'hFFFFF, 20'h33333, 1, 1, "R6 overwrite");
        look(20'hFFFFF, 12'h010, 1, 1, "R6 new frame and rights");

        // R10: lookup concurrent with each invalidation source
        idle_inputs(); lk_valid = 1; lk_vpn = 20'h00042; inv_all = 1;
        tick("R10 lookup during inv_all");
        look(20'h12345, 12'h001, 0, 0, "R8 empty after inv_all");
        fill(20'h00042, 20'h11111, 1, 1, "R5 refill");
        idle_inputs(); lk_valid = 1; lk_vpn = 20'h00042; dirbase_wr = 1;
        tick("R10 lookup during dirbase_wr");
        look(20'h00042, 12'h001, 0, 0, "R9 empty after dirbase_wr");
        // R8: fill in the invalidation cycle is discarded
        idle_inputs(); fill_en = 1; fill_vpn = 20'h00777; fill_pfn = 20'h22222;
        fill_user_ok = 1; fill_wr_ok = 1; inv_all = 1;
        tick("R8 fill dropped");
        look(20'h00777, 12'h001, 0, 0, "R8 dropped fill misses");
        idle_inputs(); fill_en = 1; fill_vpn = 20'h00778; dirbase_wr = 1;
        tick("R9 fill dropped");
        look(20'h00778, 12'h001, 0, 0, "R9 dropped fill misses");

        // R7: fill beyond capacity, several rounds of replacement
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < N + 5; i++)
                fill(20'h00100 + 20'(r * 64 + i), 20'h40000 + 20'(r * 64 + i), 1, 1, "R7 fill");
            for (int i = 0; i < N + 5; i++)
                look(20'h00100 + 20'(r * 64 + i), 12'(i), 1, 1, "R7 residency");
        end

        // mixed pseudo-random traffic against the model (R2 R3 R4 R11)
        lfsr = 32'h1ACE5EED;
        for (int c = 0; c < 2000; c++) begin
            idle_inputs();
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lk_valid = lfsr[0];
            lk_vpn = 20'(lfsr[8:4] % 24);
            lk_off = lfsr[20:9];
            lk_user = lfsr[21]; lk_write = lfsr[22];
            fill_en = lfsr[23] & lfsr[24];
            fill_vpn = 20'(lfsr[29:25] % 24);
            fill_pfn = lfsr[31:12];
            fill_user_ok = lfsr[2]; fill_wr_ok = lfsr[3];
            inv_all = (lfsr[31:26] == 6'h3F);
            dirbase_wr = (lfsr[31:26] == 6'h15);
            tick("R2 random traffic");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule